// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit sits beside a 32-bit integer datapath and holds its own 64-bit accumulator, made of an upper word (HI) and a lower word (LO). Each cycle the datapath may present an operation code and two 32-bit operands. The unit accepts the operation when `opValid` is high and `busy` is low.

Most operations finish at the edge that accepts them:

- Signed and unsigned multiply write the full 64-bit product into HI/LO.
- Unsigned multiply-accumulate and multiply-subtract update the current HI/LO value.
- Move-to loads one operand into HI or LO.

Three operations return a word on the result port one cycle after acceptance, marked by `resValid`:

- the three-operand multiply, which leaves HI/LO untouched;
- move-from-HI;
- move-from-LO.

Divide is iterative and resolves one quotient bit per cycle. During that time `busy` is high, and no new operation is taken. An issuer that wants a move-from after a divide holds it until `busy` drops. The divide then leaves the remainder in HI and the quotient in LO. Dividing by zero raises no trap. It produces a fixed result.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO hold zero, `busy` is low and `resValid` is low.
- R2: Signed multiply (code 1) writes the 64-bit two's-complement product of opA and opB into {HI,LO}, with the upper half in HI.
- R3: Unsigned multiply (code 2) writes the 64-bit unsigned product into {HI,LO}.
- R4: Multiply-accumulate (code 5) sets {HI,LO} to {HI,LO} plus the unsigned product of opA and opB, modulo 2^64.
- R5: Multiply-subtract (code 6) sets {HI,LO} to {HI,LO} minus the unsigned product, modulo 2^64.
- R6: Three-operand multiply (code 7) returns the low 32 bits of the product on `resData` in the cycle after acceptance, and leaves HI and LO unchanged.
- R7: Move-to-HI (code 10) and move-to-LO (code 11) load opA into the named register. Move-from-HI (code 8) and move-from-LO (code 9) return the held value on `resData` in the cycle after acceptance.
- R8: An accepted divide (code 3 signed, code 4 unsigned) raises `busy` in the next cycle and holds it for exactly 32 cycles. HI/LO carry the divide's result from the first cycle in which `busy` is low again.
- R9: Signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R10: Unsigned divide puts opA mod opB in HI and opA / opB in LO.
- R11: A divide by zero, signed or unsigned, gives LO = 0xFFFFFFFF and HI = opA.
- R12: An operation presented while `busy` is high is not accepted and has no effect on HI, LO or the result port.
- R13: `resValid` is high for exactly one cycle after each accepted code 7, 8 or 9, and is low at all other times. Code 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation presented this cycle |
| opCode | input | 4 | Operation code (see requirements) |
| opA | input | 32 | First operand (rs; dividend; move-to source) |
| opB | input | 32 | Second operand (rt; divisor) |
| busy | output | 1 | Divide in progress; no operation is accepted |
| resValid | output | 1 | `resData` carries a returned word |
| resData | output | 32 | Returned word for the register file |

## Verification
Each result has its own due cycle:

- Multiply, accumulate and move-to results sit in HI/LO from the edge that accepts them.
- A word returned on the port appears one cycle after acceptance.
- A divide's HI/LO are due 32 cycles after acceptance, the same edge at which `busy` falls.

The bench keeps a reference model built on 64-bit integers and steps it on each rising edge, applying the same acceptance rule. It compares `busy`, `resValid` and `resData` with the model on every falling edge. Every returned word is therefore checked in exactly its due cycle, and HI/LO are observed through move-from reads issued after each operation.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_MULS  = 4'd1,
    OP_MULU  = 4'd2,
    OP_DIVS  = 4'd3,
    OP_DIVU  = 4'd4,
    OP_MADDU = 4'd5,
    OP_MSUBU = 4'd6,
    OP_MUL3  = 4'd7,
    OP_MFHI  = 4'd8,
    OP_MFLO  = 4'd9,
    OP_MTHI  = 4'd10,
    OP_MTLO  = 4'd11
  } mdOp_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic mulWr;
    logic mulSigned;
    logic accAdd;
    logic accSub;
    logic mul3;
    logic rdHi;
    logic rdLo;
    logic wrHi;
    logic wrLo;
    logic divLoad;
    logic divSigned;
    logic divStep;
    logic divDone;
  } mdStrobe_t;

endpackage

// File: rtl/hilo_ctrl.sv
module hilo_ctrl
  import hilo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  output mdStrobe_t  strb,
  output logic       busy,
  output logic       resValid
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  logic             running;
  logic [CNT_W-1:0] stepCnt;
  logic             accept;
  mdOp_e            op;

  assign accept = opValid & ~running;
  assign op     = mdOp_e'(opCode);
  assign busy   = running;

  always_comb begin
    strb = '0;
    if (accept) begin
      unique case (op)
        OP_MULS:  begin strb.mulWr = 1'b1; strb.mulSigned = 1'b1; end
        OP_MULU:  strb.mulWr = 1'b1;
        OP_MADDU: strb.accAdd = 1'b1;
        OP_MSUBU: strb.accSub = 1'b1;
        OP_MUL3:  strb.mul3 = 1'b1;
        OP_MFHI:  strb.rdHi = 1'b1;
        OP_MFLO:  strb.rdLo = 1'b1;
        OP_MTHI:  strb.wrHi = 1'b1;
        OP_MTLO:  strb.wrLo = 1'b1;
        OP_DIVS:  begin strb.divLoad = 1'b1; strb.divSigned = 1'b1; end
        OP_DIVU:  strb.divLoad = 1'b1;
        default:  ;
      endcase
    end
    if (running) begin
      strb.divStep = 1'b1;
      strb.divDone = (stepCnt == LAST_STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      stepCnt  <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strb.mul3 | strb.rdHi | strb.rdLo;
      if (strb.divLoad) begin
        running <= 1'b1;
        stepCnt <= '0;
      end else if (running) begin
        stepCnt <= stepCnt + 1'b1;
        if (strb.divDone) running <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/hilo_dpath.sv
module hilo_dpath
  import hilo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdStrobe_t         strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] resData
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] hiReg, loReg;
  logic [DATA_W-1:0] remReg, quoReg, dvsReg;
  logic              negQ, negR;

  logic [PROD_W-1:0] prodU, prodS, accNow;
  logic [DATA_W-1:0] magA, magB;
  logic [DATA_W:0]   shifted, trial;
  logic              fits;
  logic [DATA_W-1:0] nextRem, nextQuo, finQ, finR;

  assign prodU  = {{DATA_W{1'b0}}, opA} * {{DATA_W{1'b0}}, opB};
  assign prodS  = {{DATA_W{opA[DATA_W-1]}}, opA} * {{DATA_W{opB[DATA_W-1]}}, opB};
  assign accNow = {hiReg, loReg};

  assign magA = (strb.divSigned && opA[DATA_W-1]) ? -opA : opA;
  assign magB = (strb.divSigned && opB[DATA_W-1]) ? -opB : opB;

  // one restoring step per cycle
  assign shifted = {remReg, quoReg[DATA_W-1]};
  assign trial   = shifted - {1'b0, dvsReg};
  assign fits    = ~trial[DATA_W];
  assign nextRem = fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
  assign nextQuo = {quoReg[DATA_W-2:0], fits};
  assign finQ    = negQ ? -nextQuo : nextQuo;
  assign finR    = negR ? -nextRem : nextRem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg   <= '0;
      loReg   <= '0;
      remReg  <= '0;
      quoReg  <= '0;
      dvsReg  <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      resData <= '0;
    end else begin
      if (strb.mulWr)
        {hiReg, loReg} <= strb.mulSigned ? prodS : prodU;
      else if (strb.accAdd)
        {hiReg, loReg} <= accNow + prodU;
      else if (strb.accSub)
        {hiReg, loReg} <= accNow - prodU;
      else if (strb.wrHi)
        hiReg <= opA;
      else if (strb.wrLo)
        loReg <= opA;
      else if (strb.divDone) begin
        hiReg <= finR;
        loReg <= finQ;
      end

      if (strb.divLoad) begin
        remReg <= '0;
        quoReg <= magA;
        dvsReg <= magB;
        negQ   <= strb.divSigned & (opA[DATA_W-1] ^ opB[DATA_W-1]) & (|opB);
        negR   <= strb.divSigned & opA[DATA_W-1];
      end else if (strb.divStep) begin
        remReg <= nextRem;
        quoReg <= nextQuo;
      end

      if (strb.mul3)      resData <= prodS[DATA_W-1:0];
      else if (strb.rdHi) resData <= hiReg;
      else if (strb.rdLo) resData <= loReg;
    end
  end

endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busy,
  output logic              resValid,
  output logic [DATA_W-1:0] resData
);
  mdStrobe_t strb;

  hilo_ctrl #(.DATA_W(DATA_W)) ctrlI (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .strb(strb), .busy(busy), .resValid(resValid)
  );

  hilo_dpath #(.DATA_W(DATA_W)) dpathI (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .resData(resData)
  );

endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk
  import hilo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              busy,
  input logic              resValid,
  input logic [DATA_W-1:0] resData
);
  logic [7:0]        busyRun;
  logic [DATA_W-1:0] lowProd;
  logic              takeRet, takeDiv;

  assign lowProd = opA * opB;
  assign takeRet = opValid && !busy &&
                   (opCode == OP_MUL3 || opCode == OP_MFHI || opCode == OP_MFLO);
  assign takeDiv = opValid && !busy && (opCode == OP_DIVS || opCode == OP_DIVU);

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= busy ? busyRun + 1'b1 : '0;
  end

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == 8'(DATA_W));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeDiv |=> busy);

  // R13
  ret_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeRet |=> resValid);

  // R6
  mul3_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy && opCode == OP_MUL3) |=> resData == $past(lowProd));

  // R12
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !resValid);

endmodule

bind hilo_muldiv hilo_muldiv_chk #(.DATA_W(DATA_W)) chkI (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .opA(opA), .opB(opB), .busy(busy), .resValid(resValid), .resData(resData)
);

// File: tb/tb_hilo_muldiv.sv
module tb_hilo_muldiv;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [31:0] opA = '0, opB = '0;
  logic        busy, resValid;
  logic [31:0] resData;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  hilo_muldiv dut (.*);

  always #4 clk = ~clk;

  // reference model state
  logic [31:0] mHi, mLo, pHi, pLo, mResD;
  int          mBusy;
  bit          mResV;
  string       curTag = "R1", mTag = "R1";

  always @(posedge clk) begin
    logic [63:0] p;
    longint sa, sb;
    if (!rstN) begin
      mHi = 0; mLo = 0; mBusy = 0; mResV = 0; mResD = 0;
    end else begin
      mResV = 0;
      if (mBusy > 0) begin
        mBusy--;
        if (mBusy == 0) begin mHi = pHi; mLo = pLo; end
      end else if (opValid) begin
        mTag = curTag;
        case (opCode)
          1: begin p = longint'($signed(opA)) * longint'($signed(opB)); {mHi, mLo} = p; end
          2: begin p = {32'b0, opA} * {32'b0, opB}; {mHi, mLo} = p; end
          5: begin p = {32'b0, opA} * {32'b0, opB}; {mHi, mLo} = {mHi, mLo} + p; end
          6: begin p = {32'b0, opA} * {32'b0, opB}; {mHi, mLo} = {mHi, mLo} - p; end
          7: begin p = longint'($signed(opA)) * longint'($signed(opB)); mResV = 1; mResD = p[31:0]; end
          8: begin mResV = 1; mResD = mHi; end
          9: begin mResV = 1; mResD = mLo; end
          10: mHi = opA;
          11: mLo = opA;
          3, 4: begin
            if (opB == 0) begin pLo = 32'hFFFF_FFFF; pHi = opA; end
            else begin
              if (opCode == 3) begin sa = longint'($signed(opA)); sb = longint'($signed(opB)); end
              else begin sa = longint'({32'b0, opA}); sb = longint'({32'b0, opB}); end
              p = 64'(sa / sb); pLo = p[31:0];
              p = 64'(sa % sb); pHi = p[31:0];
            end
            mBusy = 32;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R8 busy", 32'(busy), 32'(mBusy > 0));
      check("R13 resValid", 32'(resValid), 32'(mResV));
      if (mResV && resValid) check(mTag, resData, mResD);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic issue(string tag, int code, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    opValid = 1'b0;
    while (busy) @(negedge clk);
    curTag = tag; opValid = 1'b1; opCode = 4'(code); opA = a; opB = b;
  endtask

  task automatic readBoth(string tag);
    issue(tag, 8, 0, 0);
    issue(tag, 9, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 resValid", 32'(resValid), 0);
    readBoth("R1");

    issue("R7", 10, 32'h1234_5678, 0);
    issue("R7", 11, 32'h9ABC_DEF0, 0);
    readBoth("R7");

    issue("R2", 1, -32'sd3, 32'd7);          readBoth("R2");
    issue("R2", 1, 32'h8000_0000, 32'h8000_0000); readBoth("R2");
    issue("R3", 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF); readBoth("R3");
    issue("R4", 5, 32'hFFFF_FFFF, 32'd2);    readBoth("R4");
    issue("R5", 10, 0, 0); issue("R5", 11, 5, 0);
    issue("R5", 6, 32'd3, 32'd4);            readBoth("R5");
    issue("R6", 7, -32'sd5, 32'd100000);
    issue("R6", 7, 32'h8000_0001, 32'hFFFF_FFFF); readBoth("R6");

    issue("R9", 3, -32'sd7, 32'd2);          readBoth("R9");
    issue("R9", 3, 32'd7, -32'sd2);          readBoth("R9");
    issue("R9", 3, 32'h8000_0000, 32'hFFFF_FFFF); readBoth("R9");
    issue("R10", 4, 32'hFFFF_FFFF, 32'd3);   readBoth("R10");
    issue("R10", 4, 32'd5, 32'hFFFF_FFF0);   readBoth("R10");
    issue("R11", 3, -32'sd9, 32'd0);         readBoth("R11");
    issue("R11", 4, 32'hDEAD_BEEF, 32'd0);   readBoth("R11");

    // R12: hold other operations against a running divide
    issue("R12", 4, 32'd1000, 32'd7);
    @(negedge clk);
    curTag = "R12"; opValid = 1'b1; opCode = 4'd11; opA = 32'h5555_5555;
    repeat (5) @(negedge clk);
    opCode = 4'd8;
    repeat (5) @(negedge clk);
    opValid = 1'b0;
    readBoth("R12");

    for (int i = 0; i < 60; i++) begin
      int c;
      c = 1 + int'($urandom_range(10));
      issue("R13", c, $urandom, (i % 9 == 0) ? 32'd0 : $urandom);
      if (i % 4 == 0) readBoth("R13");
    end

    @(negedge clk);
    opValid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule